// File: doc/BRIEF.md
# SPI Bus Master with Contention Fault

This block is a byte-wide SPI master. Software configures it through three small registers: control/status, data and clock divider. A write to the data register starts a transfer. The block shifts the written byte out on MOSI, most significant bit first. On the same SCK edges it shifts the byte returned on MISO into the same shift register. When the eighth bit is in, the received byte is copied to a read-side buffer and one completion flag is raised. That one flag means both "sent" and "received".

A two-bit slave-select mode field in the control register decides how the NSS pin is used:

- Multi-master mode: NSS is a monitored input. A low level means another master has taken the bus. The block then clears its own enable bits, abandons any transfer in flight and latches a fault flag. The block stays off until software enables it again.
- 3-wire mode: the pin is ignored.
- 4-wire mode: the pin is an output whose level software sets directly.

SCK idles low. The master samples MISO on the rising edge and changes MOSI on the falling edge. Each SCK half period lasts (divider + 1) system clocks.

Top module: `spim_mf`

Register map. Address 0 is control/status, 1 is data, 2 is divider.

| Bit | Function |
|-----|----------|
| 0 | SPI enable |
| 1 | master enable |
| 2 | interrupt enable |
| 4:3 | slave-select mode |
| 5 | completion flag |
| 6 | fault flag |
| 7 | write-collision flag |

## Requirements
- R1: A transfer sends the data-register byte on MOSI MSB first, and afterwards `rx_data` holds the byte the slave returned on MISO, also MSB first.
- R2: Control bit 5 (completion) sets at the end of every finished byte. It stays set until a control write puts 0 in bit 5. Writing 1 there leaves it unchanged.
- R3: After reset the control readout is 8'h08 (mode 2'b01, enables and flags 0), `sck` is low, `nss_oe` and `irq` are low and `rx_data` is 0.
- R4: In mode 2'b00, `nss_oe` is 0 and a low `nss_in` has no effect: no fault, and transfers complete.
- R5: With mode bit 4 set, `nss_oe` is 1 and `nss_out` equals mode bit 3, and `nss_in` is ignored.
- R6: In mode 2'b01 with bit 0 set, a low `nss_in` (after a 2-flop synchronizer) clears bits 0 and 1 and sets fault bit 6. Data writes then start nothing until software sets the enables again.
- R7: `irq` is high one cycle after interrupt enable (bit 2) is set together with the completion or fault flag.
- R8: A data write starts a transfer only when bits 0 and 1 are both set and no transfer is running. A data write during a transfer is ignored and sets bit 7.
- R9: A fault during a transfer aborts it: `sck` returns low, the completion flag stays clear and `rx_data` keeps its old value.
- R10: Each SCK half period lasts (divider register + 1) system clocks, so rising edges are 2*(div+1) clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register select: 0 control, 1 data, 2 divider |
| reg_wdata | input | 8 | register write data |
| ctrl_rd | output | 8 | control/status readout |
| rx_data | output | 8 | last received byte |
| irq | output | 1 | interrupt request |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| nss_in | input | 1 | slave-select pin input |
| nss_out | output | 1 | slave-select pin output level |
| nss_oe | output | 1 | slave-select pin output enable |

## Verification
The assertions take for granted that `nss_in` and `miso` change away from the clock edge. They also assume software does not rewrite the divider while a transfer is running. The bench drives every input on the falling system clock edge. It models the slave so that MISO only changes on falling SCK edges, and it changes the divider only between transfers.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    NSS_3W    = 2'b00,
    NSS_MM    = 2'b01,
    NSS_4W_LO = 2'b10,
    NSS_4W_HI = 2'b11
  } nss_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  localparam int B_SPIEN = 0;
  localparam int B_MSTEN = 1;
  localparam int B_IE    = 2;
  localparam int B_MODE0 = 3;
  localparam int B_MODE1 = 4;
  localparam int B_DONE  = 5;
  localparam int B_FAULT = 6;
  localparam int B_WCOL  = 7;
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] tx,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx
);
  localparam int HC_W    = $clog2(2*DATA_W);
  localparam int HC_LAST = 2*DATA_W - 1;

  logic              busy_q, sck_q, rbit_q, done_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [HC_W-1:0]   half_q;
  logic [DATA_W-1:0] sreg_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      rbit_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
      sreg_q <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
      end else if (start && !busy_q) begin
        busy_q <= 1'b1;
        sreg_q <= tx;
        cnt_q  <= '0;
        half_q <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q >= div) begin
          cnt_q  <= '0;
          sck_q  <= ~sck_q;
          half_q <= half_q + 1'b1;
          if (!sck_q) begin
            rbit_q <= miso;
          end else begin
            sreg_q <= {sreg_q[DATA_W-2:0], rbit_q};
            if (half_q == HC_W'(HC_LAST)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              rx_q   <= {sreg_q[DATA_W-2:0], rbit_q};
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = sreg_q[DATA_W-1];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  a_r9_abort_idles: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy_q && !sck_q));
  a_r10_sck_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sck_q);
  a_r2_done_ends_transfer: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/spim_mf.sv
module spim_mf #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              nss_in,
  output logic              nss_out,
  output logic              nss_oe
);
  import spim_pkg::*;

  logic             spien_q, msten_q, ie_q, done_q, fault_q, wcol_q, irq_q;
  nss_mode_e        mode_q;
  logic [DIV_W-1:0] div_q;
  logic             nss_s, busy, done_p, fault_hit, wr_ctrl, wr_data, wr_div, go;

  spim_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(nss_in), .q(nss_s)
  );

  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_div    = reg_wr && (reg_addr == ADDR_DIV);
  assign fault_hit = (mode_q == NSS_MM) && spien_q && !nss_s;
  assign go        = wr_data && spien_q && msten_q;

  spim_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(go), .abort(fault_hit), .div(div_q),
    .tx(reg_wdata[DATA_W-1:0]), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(busy), .done(done_p), .rx(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spien_q <= 1'b0;
      msten_q <= 1'b0;
      ie_q    <= 1'b0;
      mode_q  <= NSS_MM;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      wcol_q  <= 1'b0;
      irq_q   <= 1'b0;
      div_q   <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        spien_q <= reg_wdata[B_SPIEN];
        msten_q <= reg_wdata[B_MSTEN];
        ie_q    <= reg_wdata[B_IE];
        mode_q  <= nss_mode_e'({reg_wdata[B_MODE1], reg_wdata[B_MODE0]});
        if (!reg_wdata[B_DONE])  done_q  <= 1'b0;
        if (!reg_wdata[B_FAULT]) fault_q <= 1'b0;
        if (!reg_wdata[B_WCOL])  wcol_q  <= 1'b0;
      end
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      if (done_p) done_q <= 1'b1;
      if (wr_data && busy) wcol_q <= 1'b1;
      if (fault_hit) begin
        spien_q <= 1'b0;
        msten_q <= 1'b0;
        fault_q <= 1'b1;
      end
      irq_q <= ie_q && (done_q || fault_q);
    end
  end

  assign ctrl_rd = {wcol_q, fault_q, done_q, mode_q[1], mode_q[0], ie_q, msten_q, spien_q};
  assign irq     = irq_q;
  assign nss_oe  = mode_q[1];
  assign nss_out = mode_q[1] & mode_q[0];

  a_r6_fault_disables: assert property (@(posedge clk) disable iff (rst)
    fault_hit |=> (!spien_q && !msten_q && fault_q));
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !wr_ctrl) |=> done_q);
  a_r8_wcol_on_busy_write: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy) |=> wcol_q);
  a_r7_irq_follows_flags: assert property (@(posedge clk) disable iff (rst)
    (ie_q && (done_q || fault_q)) |=> irq_q);
endmodule

// File: tb/spim_mf_bench.sv
module spim_mf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] ctrl_rd, rx_data;
  logic       irq, sck, mosi, nss_out, nss_oe;
  logic       nss_in = 1'b1;
  logic [7:0] slv = 8'd0;
  logic [7:0] cap = 8'd0;
  logic       miso;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int last_rise = 0;
  int prev_rise = 0;
  logic [15:0] sb_q[$];
  logic done_prev = 1'b0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  spim_mf u_spim_mf (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctrl_rd(ctrl_rd), .rx_data(rx_data), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .nss_in(nss_in), .nss_out(nss_out), .nss_oe(nss_oe)
  );

  assign miso = slv[7];
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge sck) slv <= {slv[6:0], 1'b0};
  always @(posedge sck) begin
    cap       <= {cap[6:0], mosi};
    prev_rise <= last_rise;
    last_rise <= cyc;
    rise_cnt  <= rise_cnt + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (ctrl_rd[5]) return;
      @(negedge clk);
    end
    check("R2 completion timeout", ctrl_rd[5], 1'b1);
  endtask

  // driver: clear completion, push expectation, load slave, start
  task automatic xfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] sd);
    wr(2'd0, ctl & 8'hDF);
    sb_q.push_back({tx, sd});
    slv = sd;
    wr(2'd1, tx);
    wait_done();
    idle(2);
  endtask

  // monitor: on each rising completion flag compare against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (ctrl_rd[5] && !done_prev) begin
        if (sb_q.size() == 0) begin
          check("R1 unexpected completion", 8'h01, 8'h00);
        end else begin
          logic [15:0] e;
          e = sb_q.pop_front();
          check("R1 rx_data from slave", rx_data, e[7:0]);
          check("R1 slave saw MOSI byte", cap, e[15:8]);
        end
      end
      done_prev = ctrl_rd[5];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0;
    logic [7:0] rx_keep;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R3 reset ctrl", ctrl_rd, 8'h08);
    check("R3 reset sck", sck, 1'b0);
    check("R3 reset nss_oe", nss_oe, 1'b0);
    check("R3 reset irq", irq, 1'b0);
    check("R3 reset rx", rx_data, 8'h00);

    // multi-master, enabled, several patterns and dividers
    wr(2'd2, 8'd1);
    xfer(8'hEB, 8'hA5, 8'h3C);
    check("R2 completion set", ctrl_rd[5], 1'b1);
    wr(2'd0, 8'hEB);
    idle(1);
    check("R2 write 1 keeps flag", ctrl_rd[5], 1'b1);
    wr(2'd0, 8'hCB);
    idle(1);
    check("R2 write 0 clears flag", ctrl_rd[5], 1'b0);
    wr(2'd2, 8'd0);
    xfer(8'hEB, 8'h00, 8'hFF);
    xfer(8'hEB, 8'hFF, 8'h00);
    wr(2'd2, 8'd3);
    xfer(8'hEB, 8'h81, 8'h7E);
    check("R10 SCK period div=3", 8'(last_rise - prev_rise), 8'd8);

    // interrupt
    wr(2'd0, 8'hEF);
    idle(2);
    check("R7 irq on completion", irq, 1'b1);
    wr(2'd0, 8'hCF);
    idle(2);
    check("R7 irq drops after clear", irq, 1'b0);

    // write collision
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h4B);
    sb_q.push_back({8'hC3, 8'h96});
    slv = 8'h96;
    wr(2'd1, 8'hC3);
    idle(5);
    wr(2'd1, 8'h11);
    idle(1);
    check("R8 wcol set on busy write", ctrl_rd[7], 1'b1);
    wait_done();
    idle(2);

    // disabled: data write starts nothing
    wr(2'd0, 8'h08);
    r0 = rise_cnt;
    wr(2'd1, 8'h55);
    idle(40);
    check("R8 disabled write no sck", 8'(rise_cnt - r0), 8'd0);
    check("R8 disabled write no completion", ctrl_rd[5], 1'b0);

    // mode fault mid-transfer
    rx_keep = rx_data;
    wr(2'd0, 8'h0F);
    slv = 8'h99;
    wr(2'd1, 8'h5A);
    idle(6);
    nss_in = 1'b0;
    idle(6);
    check("R6 enables cleared", {6'd0, ctrl_rd[1:0]}, 8'h00);
    check("R6 fault set", ctrl_rd[6], 1'b1);
    check("R9 sck idle after abort", sck, 1'b0);
    check("R9 no completion", ctrl_rd[5], 1'b0);
    check("R9 rx unchanged", rx_data, rx_keep);
    check("R7 irq on fault", irq, 1'b1);
    nss_in = 1'b1;
    idle(3);
    r0 = rise_cnt;
    wr(2'd1, 8'h77);
    idle(40);
    check("R6 stays disabled", 8'(rise_cnt - r0), 8'd0);
    wr(2'd0, 8'h8B);
    idle(1);
    check("R6 fault cleared by write 0", ctrl_rd[6], 1'b0);
    xfer(8'hAB, 8'h3E, 8'hE3);

    // 3-wire: NSS ignored
    wr(2'd0, 8'h03);
    nss_in = 1'b0;
    idle(4);
    check("R4 nss_oe low", nss_oe, 1'b0);
    xfer(8'h03, 8'h6D, 8'hB2);
    check("R4 no fault", ctrl_rd[6], 1'b0);
    check("R4 still enabled", {6'd0, ctrl_rd[1:0]}, 8'h03);

    // 4-wire: NSS output driven by low mode bit
    wr(2'd0, 8'h13);
    idle(1);
    check("R5 nss_oe high", nss_oe, 1'b1);
    check("R5 nss_out low", nss_out, 1'b0);
    wr(2'd0, 8'h1B);
    idle(1);
    check("R5 nss_out high", nss_out, 1'b1);
    xfer(8'h1B, 8'h24, 8'hDB);
    check("R5 no fault with nss_in low", ctrl_rd[6], 1'b0);
    check("R1 scoreboard drained", 8'(sb_q.size()), 8'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule